// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two operands held in signed-magnitude form: a sign bit at the top, with 1 meaning negative, above an unsigned magnitude of `MAG_W` bits. A one-cycle `start` pulse captures both operands and the operation select into internal registers. In the next cycle the block returns the signed-magnitude result together with a single-cycle `done` strobe.

The result comes from magnitude arithmetic, not from two's-complement arithmetic. A subtraction first flips the sign of the second operand. The XOR of the two effective signs then chooses the path. Equal signs add the magnitudes. Different signs subtract the smaller magnitude from the larger, and the result takes the sign of the operand with the larger magnitude. A carry out of the magnitude sum raises an overflow flag. A zero result is always reported with a positive sign.

Top module: `sm_addsub`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `result` is 0, `done` is 0 and `ovf` is 0.
- R2: `done` is high for exactly the cycle after each cycle in which `start` is high, and is low otherwise. Back-to-back starts give back-to-back strobes.
- R3: When the effective signs agree and the magnitude sum does not fit in `MAG_W` bits, `ovf` is 1 and the magnitude field holds the sum modulo 2^MAG_W. `ovf` is 0 for every result from differing signs.
- R4: With `op_sub`=0 (add) and equal operand signs, the result magnitude is the sum of the magnitudes, and the result sign is the common sign.
- R5: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller, and the result sign is the sign of the operand with the larger magnitude.
- R6: With `op_sub`=1 (subtract), the result equals the addition of the first operand and the second operand with its sign bit inverted.
- R7: A result whose magnitude field is zero always has its sign bit at 0. This covers equal magnitudes with differing signs, zero operands, and an overflowed sum that wraps to zero.
- R8: Operands and `op_sub` are captured only in cycles where `start` is high. Changing them while `start` is low leaves `result` and `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture operands and begin an operation |
| op_sub | input | 1 | 0 = add, 1 = subtract (first minus second) |
| a_in | input | MAG_W+1 | First operand: sign in MSB, magnitude below |
| b_in | input | MAG_W+1 | Second operand: sign in MSB, magnitude below |
| result | output | MAG_W+1 | Signed-magnitude result, held until the next start |
| done | output | 1 | One-cycle strobe: result valid |
| ovf | output | 1 | Magnitude overflow of the last operation |

## Verification
The operations are chosen to cover every path. There are same-sign additions of both polarities. There are mixed-sign cases where each operand in turn holds the larger magnitude, which separates a sign taken from the larger magnitude from a sign taken from the first operand. Subtractions with every sign pairing show whether the second sign is inverted before the path is chosen. Equal magnitudes, all-zero operands and a sum that wraps exactly to zero probe the negative-zero rule, and sums just above the magnitude range probe overflow and truncation. Idle cycles with changing operands, back-to-back starts and a long run of random operations check capture and strobe timing against an integer model.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    SM_ADD = 1'b0,
    SM_SUB = 1'b1
  } sm_op_e;

  typedef enum logic {
    PATH_SUM  = 1'b0,
    PATH_DIFF = 1'b1
  } sm_path_e;
endpackage

// File: rtl/sm_in_stage.sv
module sm_in_stage #(
  parameter int MAG_W = 8,
  localparam int W = MAG_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_sub,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  output logic [W-1:0]  a_q,
  output logic [W-1:0]  b_q,
  output sm_pkg::sm_op_e op_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= sm_pkg::SM_ADD;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) begin
        a_q  <= a_in;
        b_q  <= b_in;
        op_q <= sm_pkg::sm_op_e'(op_sub);
      end
    end
  end
endmodule

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
  parameter int MAG_W = 8
) (
  input  logic [MAG_W-1:0] x,
  input  logic [MAG_W-1:0] y,
  output logic             x_ge_y
);
  logic [MAG_W:0] gt_c;
  logic [MAG_W:0] eq_c;

  assign gt_c[MAG_W] = 1'b0;
  assign eq_c[MAG_W] = 1'b1;

  for (genvar i = MAG_W - 1; i >= 0; i--) begin : g_bit
    assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & x[i] & ~y[i]);
    assign eq_c[i] = eq_c[i+1] & ~(x[i] ^ y[i]);
  end

  assign x_ge_y = gt_c[0] | eq_c[0];
endmodule

// File: rtl/sm_mag_core.sv
module sm_mag_core #(
  parameter int MAG_W = 8,
  localparam int W = MAG_W + 1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  sm_pkg::sm_op_e op,
  input  logic           a_ge_b,
  output logic [W-1:0]   res,
  output logic           ovf
);
  logic             sa, sb_eff;
  logic [MAG_W-1:0] ma, mb, mag;
  logic [MAG_W:0]   sum;
  logic             sgn;
  sm_pkg::sm_path_e path;

  always_comb begin
    sa     = a[W-1];
    sb_eff = b[W-1] ^ (op == sm_pkg::SM_SUB);
    ma     = a[MAG_W-1:0];
    mb     = b[MAG_W-1:0];
    path   = (sa ^ sb_eff) ? sm_pkg::PATH_DIFF : sm_pkg::PATH_SUM;
    sum    = {1'b0, ma} + {1'b0, mb};
    if (path == sm_pkg::PATH_SUM) begin
      mag = sum[MAG_W-1:0];
      ovf = sum[MAG_W];
      sgn = sa;
    end else begin
      mag = a_ge_b ? (ma - mb) : (mb - ma);
      ovf = 1'b0;
      sgn = a_ge_b ? sa : sb_eff;
    end
    res = {sgn & (|mag), mag};
  end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int MAG_W = 8,
  localparam int W = MAG_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_sub,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         done,
  output logic         ovf
);
  logic [W-1:0]   a_q, b_q;
  sm_pkg::sm_op_e op_q;
  logic           a_ge_b;

  sm_in_stage #(.MAG_W(MAG_W)) u_in (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .a_in(a_in), .b_in(b_in),
    .a_q(a_q), .b_q(b_q), .op_q(op_q), .valid_q(done)
  );

  sm_mag_cmp #(.MAG_W(MAG_W)) u_cmp (
    .x(a_q[MAG_W-1:0]), .y(b_q[MAG_W-1:0]), .x_ge_y(a_ge_b)
  );

  sm_mag_core #(.MAG_W(MAG_W)) u_core (
    .a(a_q), .b(b_q), .op(op_q), .a_ge_b(a_ge_b),
    .res(result), .ovf(ovf)
  );
endmodule

// File: rtl/sm_addsub_checker.sv
module sm_addsub_checker #(
  parameter int MAG_W = 8,
  localparam int W = MAG_W + 1
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         op_sub,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] result,
  input logic         done,
  input logic         ovf
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  p_done_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(result) && $stable(ovf)));

  p_no_neg_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (result[MAG_W-1:0] == '0) |-> !result[W-1]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(a_in[W-1]) ^ $past(b_in[W-1]) ^ $past(op_sub))) |-> !ovf);

  p_diff_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(a_in[W-1]) ^ $past(b_in[W-1]) ^ $past(op_sub)))
      |-> ((result[MAG_W-1:0] <= $past(a_in[MAG_W-1:0])) ||
           (result[MAG_W-1:0] <= $past(b_in[MAG_W-1:0]))));
endmodule

bind sm_addsub sm_addsub_checker #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
  .a_in(a_in), .b_in(b_in), .result(result), .done(done), .ovf(ovf)
);

// File: tb/sm_addsub_test.sv
module sm_addsub_test;
  localparam int MAG_W = 8;
  localparam int W = MAG_W + 1;
  localparam int LIM = 1 << MAG_W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] result;
  logic         done;
  logic         ovf;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [W-1:0] exp_res = '0;
  logic         exp_ovf = 1'b0;
  logic         exp_done = 1'b0;

  always #4 clk = ~clk;

  sm_addsub #(.MAG_W(MAG_W)) uut (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .a_in(a_in), .b_in(b_in), .result(result), .done(done), .ovf(ovf)
  );

  function automatic logic [W-1:0] mk(input bit neg, input int mag);
    return {neg, mag[MAG_W-1:0]};
  endfunction

  task automatic model(input bit sub, input logic [W-1:0] a, input logic [W-1:0] b);
    int av, bv, r, m;
    av = a[W-1] ? -int'(a[MAG_W-1:0]) : int'(a[MAG_W-1:0]);
    bv = b[W-1] ? -int'(b[MAG_W-1:0]) : int'(b[MAG_W-1:0]);
    r  = sub ? av - bv : av + bv;
    m  = (r < 0) ? -r : r;
    exp_ovf = (m >= LIM);
    m = m % LIM;
    exp_res = {(r < 0) && (m != 0), m[MAG_W-1:0]};
  endtask

  task automatic compare(input string tag);
    checks++;
    if (result !== exp_res || ovf !== exp_ovf || done !== exp_done) begin
      failures++;
      $display("FAIL %s result=%h ovf=%b done=%b expected result=%h ovf=%b done=%b",
               tag, result, ovf, done, exp_res, exp_ovf, exp_done);
    end
  endtask

  // Drive at a negedge, model the next posedge, check at the following negedge.
  task automatic step(input string tag, input bit st, input bit sub,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    start = st; op_sub = sub; a_in = a; b_in = b;
    @(posedge clk);
    exp_done = st;
    if (st) model(sub, a, b);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic op1(input string tag, input bit sub,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    step(tag, 1'b1, sub, a, b);
    step(tag, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst = 1'b0;
    step("R1 after reset", 1'b0, 1'b0, '0, '0);

    // R4: same signs add
    op1("R4 pos+pos", 1'b0, mk(0, 5), mk(0, 7));
    op1("R4 neg+neg", 1'b0, mk(1, 5), mk(1, 7));
    // R5: differing signs
    op1("R5 a larger pos", 1'b0, mk(0, 9), mk(1, 3));
    op1("R5 a larger neg", 1'b0, mk(1, 9), mk(0, 3));
    op1("R5 b larger neg", 1'b0, mk(0, 3), mk(1, 9));
    op1("R5 b larger pos", 1'b0, mk(1, 3), mk(0, 9));
    // R6: subtraction
    op1("R6 5-7", 1'b1, mk(0, 5), mk(0, 7));
    op1("R6 -5-(-7)", 1'b1, mk(1, 5), mk(1, 7));
    op1("R6 5-(-7)", 1'b1, mk(0, 5), mk(1, 7));
    op1("R6 -5-7", 1'b1, mk(1, 5), mk(0, 7));
    // R7: zero results
    op1("R7 +7 + -7", 1'b0, mk(0, 7), mk(1, 7));
    op1("R7 -7 - -7", 1'b1, mk(1, 7), mk(1, 7));
    op1("R7 -0 + -0", 1'b0, mk(1, 0), mk(1, 0));
    op1("R7 -0 - +0", 1'b1, mk(1, 0), mk(0, 0));
    // R3: overflow
    op1("R3 200+100", 1'b0, mk(0, 200), mk(0, 100));
    op1("R3 -255-1 wraps to zero", 1'b1, mk(1, 255), mk(0, 1));
    op1("R3 255+0 no carry", 1'b0, mk(0, 255), mk(0, 0));
    op1("R3 diff never overflows", 1'b1, mk(0, 255), mk(0, 255));
    // R8: operands ignored while start is low
    op1("R8 setup", 1'b0, mk(1, 40), mk(1, 2));
    for (int i = 0; i < 6; i++)
      step("R8 idle inputs ignored", 1'b0, i[0], mk(i[1], 17 * i + 3), mk(~i[1], 90));
    // R2: back-to-back starts and gaps
    step("R2 b2b first", 1'b1, 1'b0, mk(0, 1), mk(0, 2));
    step("R2 b2b second", 1'b1, 1'b1, mk(0, 1), mk(0, 2));
    step("R2 b2b third", 1'b1, 1'b0, mk(1, 100), mk(1, 200));
    step("R2 strobe ends", 1'b0, 1'b0, '0, '0);
    step("R2 still low", 1'b0, 1'b1, mk(1, 9), mk(0, 9));
    // Random mix of all paths
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      step("R4 R5 R6 R7 R3 random", ($urandom % 3) != 0, 1'($urandom), ra, rb);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule